// File: doc/BRIEF.md
# Cascadable Synchronous Counter Slice

This block is one digit of a wider synchronous counter. It counts either 0 to 9 (decade) or across the full range of its 4-bit state (binary), depending on a build parameter. All stages of a multi-digit counter share one clock. A stage moves forward only when both of its count enables are high.

The block has a parallel data input, which is taken in on a clock edge while `load` is high, and a clear. A second build parameter sets whether the clear acts on the next clock edge or forces zero at once. The carry output goes high when the stage sits at its terminal value and the carry-gating enable `chain_en` is high. The carry of one stage feeds `chain_en` of the next stage. Because `cnt_en` does not enter the carry term, a single global count enable can drive every stage while the carry chain stays short.

Top module: `casc_count_slice`

## Requirements
- R1: The state advances on a rising clock edge only when `cnt_en` and `chain_en` are both 1. Otherwise, with `clear` and `load` low, `q` holds its value.
- R2: `carry_out` is 1 exactly when `q` equals the terminal value (9 in decade mode, 15 in binary mode) and `chain_en` is 1. It does not depend on `cnt_en` and has no register delay.
- R3: With `DECADE`=1, counting goes 0,1,...,9 and then wraps to 0.
- R4: With `DECADE`=0, counting goes 0,1,...,15 and then wraps to 0. The value 9 advances to 10.
- R5: With `CLR_ASYNC`=0, a high `clear` sets `q` to 0 on the next rising clock edge and leaves `q` unchanged before that edge.
- R6: With `CLR_ASYNC`=1, a high `clear` sets `q` to 0 at once, without a clock edge.
- R7: While `load` is high at a rising edge, `q` takes the value of `data`, whatever the enables are.
- R8: The priority is: clear first, then load, then count, then hold.
- R9: In decade mode, a loaded value of 10 to 15 goes to 0 on the next count step. It does not raise `carry_out`.
- R10: Two chained stages form a two-digit counter. The upper stage advances only on edges where the lower stage's carry is high.
- R11: A low `rst_n` clears `q` to 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Clear to zero; synchronous or asynchronous by parameter |
| load | input | 1 | Synchronous parallel load strobe |
| data | input | WIDTH | Parallel load value |
| cnt_en | input | 1 | Count enable that does not gate the carry |
| chain_en | input | 1 | Count enable that also gates the carry; driven by the lower stage's carry |
| q | output | WIDTH | Current count |
| carry_out | output | 1 | Terminal count AND `chain_en` |

## Verification
The bench builds three instances. One is decade with synchronous clear, one is binary with asynchronous clear, and a third decade stage is chained above the first. Together they cover both count ranges and both clear variants. The decade instance also exercises recovery from out-of-range loads. The chained pair shows a carry crossing a digit boundary, including the tens digit moving twice over 25 counts.

// File: rtl/casc_count_pkg.sv
package casc_count_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  // Terminal value for a stage of the given width and mode.
  function automatic int unsigned term_value(input int unsigned width, input bit decade);
    if (decade) return 32'd9;
    return (32'd1 << width) - 32'd1;
  endfunction

  // One count step; anything at or past terminal returns to zero.
  function automatic int unsigned step_value(input int unsigned cur, input int unsigned term);
    if (cur >= term) return 32'd0;
    return cur + 32'd1;
  endfunction

  // Priority selection of the operation for this edge.
  function automatic cnt_op_e pick_op(input logic clr, input logic ld, input logic adv);
    if (clr) return OP_CLEAR;
    if (ld)  return OP_LOAD;
    if (adv) return OP_COUNT;
    return OP_HOLD;
  endfunction

endpackage

// File: rtl/casc_count_next.sv
module casc_count_next
  import casc_count_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned TERM  = 9
) (
  input  logic             clear,
  input  logic             load,
  input  logic             adv,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);

  cnt_op_e          op;
  logic [WIDTH-1:0] stepped;

  assign op      = pick_op(clear, load, adv);
  assign stepped = WIDTH'(step_value(32'(cur), TERM));

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = data;
      OP_COUNT: nxt = stepped;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/casc_count_carry.sv
module casc_count_carry #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned TERM  = 9
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             chain_en,
  output logic             at_term,
  output logic             over_term,
  output logic             carry
);

  localparam int unsigned FULL = (32'd1 << WIDTH) - 32'd1;

  assign at_term = (cur == WIDTH'(TERM));

  generate
    if (TERM >= FULL) begin : g_full_range
      assign over_term = 1'b0;
    end else begin : g_short_range
      assign over_term = (cur > WIDTH'(TERM));
    end
  endgenerate

  assign carry = at_term & chain_en;

endmodule

// File: rtl/casc_count_reg.sv
module casc_count_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aclr,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] cur
);

  always_ff @(posedge clk or negedge rst_n or posedge aclr) begin
    if (!rst_n)    cur <= '0;
    else if (aclr) cur <= '0;
    else           cur <= nxt;
  end

endmodule

// File: rtl/casc_count_slice.sv
module casc_count_slice
  import casc_count_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter bit          DECADE    = 1'b1,
  parameter bit          CLR_ASYNC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [WIDTH-1:0] data,
  input  logic             cnt_en,
  input  logic             chain_en,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);

  localparam int unsigned TERM = term_value(WIDTH, DECADE);

  logic             adv_fire;
  logic             at_term;
  logic             over_term;
  logic             async_clr;
  logic [WIDTH-1:0] nxt_q;

  assign adv_fire = cnt_en & chain_en;

  generate
    if (CLR_ASYNC) begin : g_clr_async
      assign async_clr = clear;
    end else begin : g_clr_sync
      assign async_clr = 1'b0;
    end
  endgenerate

  casc_count_next #(.WIDTH(WIDTH), .TERM(TERM)) u_next (
    .clear (clear),
    .load  (load),
    .adv   (adv_fire),
    .data  (data),
    .cur   (q),
    .nxt   (nxt_q)
  );

  casc_count_reg #(.WIDTH(WIDTH)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .aclr  (async_clr),
    .nxt   (nxt_q),
    .cur   (q)
  );

  casc_count_carry #(.WIDTH(WIDTH), .TERM(TERM)) u_carry (
    .cur       (q),
    .chain_en  (chain_en),
    .at_term   (at_term),
    .over_term (over_term),
    .carry     (carry_out)
  );

endmodule

// File: rtl/casc_count_slice_chk.sv
module casc_count_slice_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             load,
  input logic [WIDTH-1:0] data,
  input logic             cnt_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] q,
  input logic             carry_out,
  input logic             adv_fire,
  input logic             at_term,
  input logic             over_term
);

  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> chain_en); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (!load && !(cnt_en && chain_en)) |=> $stable(q)); // R1

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (adv_fire && !load && !at_term && !over_term) |=> (q == WIDTH'($past(q) + 1'b1))); // R1

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (adv_fire && !load && at_term) |=> (q == '0)); // R3

  AST_OVER_RECOVER: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (adv_fire && !load && over_term) |=> (q == '0)); // R9

  AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n || clear)
    load |=> (q == $past(data))); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (q == '0)); // R8

endmodule

bind casc_count_slice casc_count_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear     (clear),
  .load      (load),
  .data      (data),
  .cnt_en    (cnt_en),
  .chain_en  (chain_en),
  .q         (q),
  .carry_out (carry_out),
  .adv_fire  (adv_fire),
  .at_term   (at_term),
  .over_term (over_term)
);

// File: tb/casc_count_slice_bench.sv
module casc_count_slice_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       t_clear = 0, t_load = 0, t_cnt = 0, t_chain = 0;
  logic [3:0] t_data = 0, t_q, hi_q;
  logic       t_carry, hi_carry;
  logic       b_clear = 0, b_load = 0, b_cnt = 0, b_chain = 0;
  logic [3:0] b_data = 0, b_q;
  logic       b_carry;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  casc_count_slice #(.WIDTH(4), .DECADE(1'b1), .CLR_ASYNC(1'b0)) u_casc_count_slice (
    .clk(clk), .rst_n(rst_n), .clear(t_clear), .load(t_load), .data(t_data),
    .cnt_en(t_cnt), .chain_en(t_chain), .q(t_q), .carry_out(t_carry));

  casc_count_slice #(.WIDTH(4), .DECADE(1'b1), .CLR_ASYNC(1'b0)) u_casc_count_slice_hi (
    .clk(clk), .rst_n(rst_n), .clear(t_clear), .load(1'b0), .data(4'd0),
    .cnt_en(t_cnt), .chain_en(t_carry), .q(hi_q), .carry_out(hi_carry));

  casc_count_slice #(.WIDTH(4), .DECADE(1'b0), .CLR_ASYNC(1'b1)) u_casc_count_slice_bin (
    .clk(clk), .rst_n(rst_n), .clear(b_clear), .load(b_load), .data(b_data),
    .cnt_en(b_cnt), .chain_en(b_chain), .q(b_q), .carry_out(b_carry));

  // {clear, load, cnt_en, chain_en, data[3:0], exp_q[3:0], exp_carry}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0100, 4'd7,  4'd7,  1'b0},  // R7 load ignores enables
    {4'b0011, 4'd0,  4'd8,  1'b0},  // R1 step
    {4'b0011, 4'd0,  4'd9,  1'b1},  // R2 carry at 9
    {4'b0010, 4'd0,  4'd9,  1'b0},  // R1 R2 chain_en low: hold, no carry
    {4'b0001, 4'd0,  4'd9,  1'b1},  // R1 R2 cnt_en low: hold, carry shown
    {4'b0011, 4'd0,  4'd0,  1'b0},  // R3 wrap
    {4'b0111, 4'd12, 4'd12, 1'b0},  // R8 load over count
    {4'b0011, 4'd0,  4'd0,  1'b0},  // R9 out of range back to 0
    {4'b0011, 4'd0,  4'd1,  1'b0},  // R3 continues
    {4'b1111, 4'd5,  4'd0,  1'b0},  // R8 clear over load
    {4'b0101, 4'd9,  4'd9,  1'b1},  // R7 R2
    {4'b1000, 4'd0,  4'd0,  1'b0}   // R5 clear
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R11 reset q", int'(t_q), 0);
    check("R11 reset bin q", int'(b_q), 0);
    check("R2 reset carry", int'(t_carry), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {t_clear, t_load, t_cnt, t_chain} = VEC[i][12:9];
      t_data = VEC[i][8:5];
      @(negedge clk);
      check($sformatf("R1 R2 R3 R5 R7 R8 R9 row %0d q", i), int'(t_q), int'(VEC[i][4:1]));
      check($sformatf("R2 row %0d carry", i), int'(t_carry), int'(VEC[i][0]));
    end
    {t_clear, t_load, t_cnt, t_chain} = 4'b0000;

    // R5: synchronous clear waits for the edge
    t_load = 1; t_data = 4'd4;
    @(negedge clk);
    t_load = 0; t_clear = 1;
    #1;
    check("R5 before edge", int'(t_q), 4);
    @(negedge clk);
    check("R5 after edge", int'(t_q), 0);
    t_clear = 0;

    // R4: binary range
    b_load = 1; b_data = 4'd9;
    @(negedge clk);
    b_load = 0; b_cnt = 1; b_chain = 1;
    @(negedge clk);
    check("R4 nine to ten", int'(b_q), 10);
    check("R2 bin no carry at 10", int'(b_carry), 0);
    b_cnt = 0; b_load = 1; b_data = 4'd14;
    @(negedge clk);
    b_load = 0; b_cnt = 1;
    @(negedge clk);
    check("R4 reach 15", int'(b_q), 15);
    check("R2 bin carry at 15", int'(b_carry), 1);
    @(negedge clk);
    check("R4 wrap", int'(b_q), 0);
    b_cnt = 0; b_chain = 0;

    // R6: asynchronous clear acts without an edge
    b_load = 1; b_data = 4'd5;
    @(negedge clk);
    b_load = 0;
    check("R7 bin load", int'(b_q), 5);
    b_clear = 1;
    #1;
    check("R6 immediate clear", int'(b_q), 0);
    @(negedge clk);
    b_clear = 0;

    // R10: two-digit chain
    do_reset();
    t_cnt = 1; t_chain = 1;
    repeat (9) @(negedge clk);
    check("R10 low at 9", int'(t_q), 9);
    check("R10 high still 0", int'(hi_q), 0);
    @(negedge clk);
    check("R10 low wrapped", int'(t_q), 0);
    check("R10 high stepped", int'(hi_q), 1);
    repeat (15) @(negedge clk);
    check("R10 low after 25", int'(t_q), 5);
    check("R10 high after 25", int'(hi_q), 2);
    t_cnt = 0;
    @(negedge clk);
    check("R1 chain hold", int'(t_q), 5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule